// File: doc/BRIEF.md
# Prescaled Four-Comparator PWM Timer

A register-mapped timer that can also make PWM waveforms. A 31-bit counter runs while it is enabled. Its value is shifted right by a 4-bit prescale amount, and the low 16 bits of the result are compared against four compare registers. Each comparator drives one output line and one pending flag. Software can poll the pending flags to line itself up with a chosen point in the cycle.

Compare register 0 can end the period. When period reset is on, the counter returns to zero once the scaled count reaches compare 0. Outputs 1 to 3 then give waveforms whose duty cycle is set by their compare values. A deglitch option delays that return by one cycle. A one-shot enable runs exactly one period and then clears itself. A sticky option keeps each pending flag set until software clears it.

The bus is a plain word-indexed interface. A write takes effect at the clock edge. Read data is combinational from the address.

Top module: `pwm_cmp_timer`

Register map (word index on `addr`):
- 0: control word. Bits 3:0 prescale shift, bit 8 sticky, bit 9 period reset, bit 10 deglitch, bit 12 continuous run, bit 13 one-shot run, bits 31:28 pending flags (bit 28+i for comparator i). All other bits read 0.
- 1: raw counter, bits 30:0 (read/write).
- 2: scaled count, 16 bits (read only).
- 4 to 7: compare registers 0 to 3, 16 bits each.

## Requirements
- R1: After reset the control word is 0, the counter is 0, all compare registers hold 0xFFFF, and all outputs and pending flags are 0.
- R2: Every defined control bit reads back in its own position. Bit 9 (period reset) and bit 10 (deglitch) are independent of each other. Undefined bits read 0.
- R3: The counter advances by one per clock only while bit 12 or bit 13 is set. With both bits clear it holds its value, even if bit 9 is set.
- R4: The scaled count at index 2 equals the low 16 bits of the counter shifted right by the prescale amount. A prescale of 15 divides by 2^15.
- R5: Output i is high exactly while the scaled count is greater than or equal to compare register i.
- R6: With bit 9 set and deglitch clear, the counter is 0 on the clock after the scaled count reaches compare 0. At prescale 0 and a preload of 0, the period is compare0+1 clocks and output 0 is high for one clock per period.
- R7: With bits 9 and 10 both set, the reset comes one clock later. The period is compare0+2 clocks at prescale 0, and output 0 is high for two clocks per period.
- R8: At prescale 0 with period reset, setting compare 1 to half of an even compare 0 makes output 1 high for half the period, rounded up.
- R9: With sticky clear, each pending flag equals its output as it was one clock earlier.
- R10: With sticky set, a pending flag that is set stays set until a control-word write puts 0 in its bit.
- R11: When the hardware returns the counter to zero (period reset or wrap), the one-shot bit clears, so the counter then stops unless bit 12 is set.
- R12: A write to index 1 preloads the counter. A single control-word write applies prescale, mode and enable bits together at one edge.
- R13: A running counter at 0x7FFFFFFF wraps to 0 on the next clock. A wrap also clears the one-shot bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we | input | 1 | Write strobe |
| addr | input | 3 | Word index of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| pwm_out | output | 4 | Comparator output lines |
| irq_pend | output | 4 | Pending flags, one per comparator |

## Verification
Timing after a stimulus:
- A register write is visible in read data and outputs from the first falling edge after the writing rising edge.
- A counter step, period reset or wrap shows on the outputs one clock after the edge that caused it.
- Pending flags follow the outputs one further clock later.
- Under deglitch, the period reset lands two clocks after the match.

The bench drives inputs on falling edges. It advances a behavioural model at each rising edge from the same inputs, and compares outputs, flags and read data 1 ns after every falling edge. Directed checks then count output-high clocks over whole periods, and read back counter and control state to confirm that stopped and one-shot states hold.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  // control-word bit positions
  localparam int CFG_STICKY = 8;
  localparam int CFG_ZERO   = 9;
  localparam int CFG_DEGL   = 10;
  localparam int CFG_ALWAYS = 12;
  localparam int CFG_ONCE   = 13;
  localparam int CFG_PEND   = 28;

  // register word indices
  localparam int REG_CFG    = 0;
  localparam int REG_COUNT  = 1;
  localparam int REG_SCALED = 2;
  localparam int REG_CMP0   = 4;

  // comparator rule: a value at or above its threshold is a hit
  function automatic logic at_or_above(input logic [31:0] value, input logic [31:0] thresh);
    return value >= thresh;
  endfunction

  // raw count divided by 2^shift, kept to 32 bits
  function automatic logic [31:0] prescale(input logic [31:0] raw, input logic [4:0] shift);
    return raw >> shift;
  endfunction
endpackage

// File: rtl/pwm_tick_counter.sv
module pwm_tick_counter
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W   = 31,
  parameter int CMP_W   = 16,
  parameter int SCALE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               zero_cmp,
  input  logic               deglitch,
  input  logic               period_hit,
  input  logic               load,
  input  logic [CNT_W-1:0]   load_val,
  input  logic [SCALE_W-1:0] scale,
  output logic [CNT_W-1:0]   count,
  output logic [CMP_W-1:0]   scaled,
  output logic               restart,
  output logic               wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic match_q;
  logic [31:0] shifted;

  always_comb begin
    shifted = prescale(32'(count), 5'(scale));
    scaled  = shifted[CMP_W-1:0];
  end

  // period end: immediately on the hit, or one clock later with deglitch
  assign restart = run && zero_cmp && (deglitch ? match_q : period_hit);
  assign wrap    = run && (count == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      match_q <= 1'b0;
    end else begin
      match_q <= run && zero_cmp && period_hit && !restart;
      if (load)
        count <= load_val;
      else if (restart || wrap)
        count <= '0;
      else if (run)
        count <= count + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pwm_cmp_lane.sv
module pwm_cmp_lane
  import pwm_timer_pkg::*;
#(
  parameter int CMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMP_W-1:0] scaled,
  input  logic [CMP_W-1:0] cmp,
  input  logic             sticky,
  input  logic             pend_wr,
  input  logic             pend_wval,
  output logic             hit,
  output logic             pend
);
  assign hit = at_or_above(32'(scaled), 32'(cmp));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pend <= 1'b0;
    else if (pend_wr)
      pend <= pend_wval;
    else if (sticky)
      pend <= pend | hit;
    else
      pend <= hit;
  end
endmodule

// File: rtl/pwm_cmp_timer.sv
module pwm_cmp_timer
  import pwm_timer_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int CNT_W   = 31,
  parameter int CMP_W   = 16,
  parameter int SCALE_W = 4,
  parameter int ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [NCH-1:0]    pwm_out,
  output logic [NCH-1:0]    irq_pend
);
  localparam logic [CMP_W-1:0] CMP_RST = {CMP_W{1'b1}};

  // named internal events
  logic               cfg_wr, cnt_wr, run, restart, wrap;
  logic [NCH-1:0]     cmp_wr;
  logic [SCALE_W-1:0] scale_q;
  logic               sticky_q, zero_q, dg_q, always_q, one_q;
  logic [CMP_W-1:0]   cmp_q [NCH];
  logic [CNT_W-1:0]   count;
  logic [CMP_W-1:0]   scaled;
  logic [31:0]        cfg_word;

  assign cfg_wr = we && (addr == ADDR_W'(REG_CFG));
  assign cnt_wr = we && (addr == ADDR_W'(REG_COUNT));
  assign run    = always_q || one_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scale_q  <= '0;
      sticky_q <= 1'b0;
      zero_q   <= 1'b0;
      dg_q     <= 1'b0;
      always_q <= 1'b0;
      one_q    <= 1'b0;
    end else if (cfg_wr) begin
      scale_q  <= wdata[SCALE_W-1:0];
      sticky_q <= wdata[CFG_STICKY];
      zero_q   <= wdata[CFG_ZERO];
      dg_q     <= wdata[CFG_DEGL];
      always_q <= wdata[CFG_ALWAYS];
      one_q    <= wdata[CFG_ONCE];
    end else if (restart || wrap) begin
      one_q    <= 1'b0;
    end
  end

  pwm_tick_counter #(
    .CNT_W(CNT_W), .CMP_W(CMP_W), .SCALE_W(SCALE_W)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .zero_cmp  (zero_q),
    .deglitch  (dg_q),
    .period_hit(pwm_out[0]),
    .load      (cnt_wr),
    .load_val  (wdata[CNT_W-1:0]),
    .scale     (scale_q),
    .count     (count),
    .scaled    (scaled),
    .restart   (restart),
    .wrap      (wrap)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    assign cmp_wr[i] = we && (addr == ADDR_W'(REG_CMP0 + i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cmp_q[i] <= CMP_RST;
      else if (cmp_wr[i])
        cmp_q[i] <= wdata[CMP_W-1:0];
    end

    pwm_cmp_lane #(.CMP_W(CMP_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .scaled   (scaled),
      .cmp      (cmp_q[i]),
      .sticky   (sticky_q),
      .pend_wr  (cfg_wr),
      .pend_wval(wdata[CFG_PEND+i]),
      .hit      (pwm_out[i]),
      .pend     (irq_pend[i])
    );
  end

  always_comb begin
    cfg_word              = '0;
    cfg_word[SCALE_W-1:0] = scale_q;
    cfg_word[CFG_STICKY]  = sticky_q;
    cfg_word[CFG_ZERO]    = zero_q;
    cfg_word[CFG_DEGL]    = dg_q;
    cfg_word[CFG_ALWAYS]  = always_q;
    cfg_word[CFG_ONCE]    = one_q;
    for (int i = 0; i < NCH; i++) cfg_word[CFG_PEND+i] = irq_pend[i];
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(REG_CFG))    rdata = cfg_word;
    if (addr == ADDR_W'(REG_COUNT))  rdata = 32'(count);
    if (addr == ADDR_W'(REG_SCALED)) rdata = 32'(scaled);
    for (int i = 0; i < NCH; i++)
      if (addr == ADDR_W'(REG_CMP0 + i)) rdata = 32'(cmp_q[i]);
  end
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int CNT_W = 31,
  parameter int NCH   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic             cnt_wr,
  input logic             run,
  input logic             sticky_q,
  input logic             one_q,
  input logic             dg_q,
  input logic             restart,
  input logic             wrap,
  input logic [CNT_W-1:0] count,
  input logic [NCH-1:0]   pwm_out,
  input logic [NCH-1:0]   irq_pend
);
  AST_HALT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(count)); // R3
  AST_STEP_WHEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_wr && !restart && !wrap) |=> (count == CNT_W'($past(count) + 1))); // R3
  AST_ZERO_AFTER_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    ((restart || wrap) && !cnt_wr) |=> (count == '0)); // R6
  AST_DEGLITCH_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && dg_q) |-> $past(pwm_out[0])); // R7
  AST_PEND_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sticky_q && !cfg_wr) |=> (irq_pend == $past(pwm_out))); // R9
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_q && !cfg_wr) |=> ((irq_pend & $past(irq_pend)) == $past(irq_pend))); // R10
  AST_ONESHOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ((restart || wrap) && one_q && !cfg_wr) |=> !one_q); // R11
endmodule

bind pwm_cmp_timer pwm_timer_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cfg_wr  (cfg_wr),
  .cnt_wr  (cnt_wr),
  .run     (run),
  .sticky_q(sticky_q),
  .one_q   (one_q),
  .dg_q    (dg_q),
  .restart (restart),
  .wrap    (wrap),
  .count   (count),
  .pwm_out (pwm_out),
  .irq_pend(irq_pend)
);

// File: tb/sim_pwm_cmp_timer.sv
`timescale 1ns/1ps
module sim_pwm_cmp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pwm_out, irq_pend;

  int tests = 0;
  int fails = 0;
  bit live = 0;

  always #5 clk = ~clk;

  pwm_cmp_timer u0 (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pwm_out(pwm_out), .irq_pend(irq_pend)
  );

  // ---------------- behavioural reference model ----------------
  longint m_cnt;
  int     m_scale, m_cmp[4];
  bit     m_st, m_zc, m_dg, m_alw, m_one, m_mq;
  bit     m_ip[4];

  function automatic longint m_scaled();
    return (m_cnt >> m_scale) & 64'hFFFF;
  endfunction

  function automatic bit m_out(int i);
    return m_scaled() >= longint'(m_cmp[i]);
  endfunction

  function automatic logic [31:0] m_cfg();
    logic [31:0] w = '0;
    w[3:0] = 4'(m_scale); w[8] = m_st; w[9] = m_zc; w[10] = m_dg;
    w[12] = m_alw; w[13] = m_one;
    for (int i = 0; i < 4; i++) w[28+i] = m_ip[i];
    return w;
  endfunction

  function automatic logic [31:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return m_cfg();
      3'd1: return 32'(m_cnt);
      3'd2: return 32'(m_scaled());
      3'd4, 3'd5, 3'd6, 3'd7: return 32'(m_cmp[a-4]);
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_scale = 0; m_st = 0; m_zc = 0; m_dg = 0; m_alw = 0; m_one = 0; m_mq = 0;
      for (int i = 0; i < 4; i++) begin m_cmp[i] = 'hFFFF; m_ip[i] = 0; end
    end else begin
      bit ge[4];
      bit run, evt, wrp;
      for (int i = 0; i < 4; i++) ge[i] = m_out(i);
      run  = m_alw || m_one;
      evt  = run && m_zc && (m_dg ? m_mq : ge[0]);
      wrp  = run && (m_cnt == 64'h7FFFFFFF);
      m_mq = run && m_zc && ge[0] && !evt;
      for (int i = 0; i < 4; i++)
        m_ip[i] = (we && addr == 0) ? wdata[28+i] : (m_st ? (m_ip[i] | ge[i]) : ge[i]);
      if (we && addr == 1) m_cnt = longint'(wdata[30:0]);
      else if (evt || wrp) m_cnt = 0;
      else if (run) m_cnt = m_cnt + 1;
      if (we && addr == 0) begin
        m_scale = int'(wdata[3:0]); m_st = wdata[8]; m_zc = wdata[9]; m_dg = wdata[10];
        m_alw = wdata[12]; m_one = wdata[13];
      end else if (evt || wrp) m_one = 0;
      if (we && addr >= 4) m_cmp[addr-4] = int'(wdata[15:0]);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    #1;
    if (live) begin
      logic [3:0] eo, ep;
      for (int i = 0; i < 4; i++) begin eo[i] = m_out(i); ep[i] = m_ip[i]; end
      chk("R5 outputs", 32'(pwm_out), 32'(eo));
      chk("R9/R10 pending", 32'(irq_pend), 32'(ep));
      chk("R2/R4 read data", rdata, m_read(addr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1; we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #2; v = rdata;
  endtask

  task automatic count_high(input int cycles, output int h0, output int h1);
    h0 = 0; h1 = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk); #2;
      h0 += int'(pwm_out[0]);
      h1 += int'(pwm_out[1]);
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, a, b;
    int h0, h1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    live = 1;

    // R1 reset state
    rd(3'd0, v); chk("R1 control", v, 32'h0);
    rd(3'd1, v); chk("R1 counter", v, 32'h0);
    rd(3'd4, v); chk("R1 compare0", v, 32'hFFFF);
    chk("R1 outputs", 32'({pwm_out, irq_pend}), 32'h0);

    // R2 read-back in place, bits 9 and 10 independent
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R2 all bits", v, 32'hF000_370F);
    wr(3'd0, 32'h0000_0200);
    rd(3'd0, v); chk("R2 zero-compare alone", v & 32'h0FFF_FFFF, 32'h200);
    wr(3'd0, 32'h0000_0400);
    rd(3'd0, v); chk("R2 deglitch alone", v & 32'h0FFF_FFFF, 32'h400);
    wr(3'd0, 32'h0);

    // R3 stopped with zero-compare, running steps by one
    wr(3'd1, 32'd5);
    wr(3'd0, 32'h200);
    repeat (6) @(negedge clk);
    rd(3'd1, v); chk("R3 held while stopped", v, 32'd5);
    wr(3'd0, 32'h1000);
    rd(3'd1, a); rd(3'd1, b); chk("R3 step per clock", b - a, 32'd1);
    wr(3'd0, 32'h0);

    // R4 prescaled count, R5 compare boundary
    wr(3'd1, 32'h0001_2345);
    wr(3'd0, 32'h4);
    rd(3'd2, v); chk("R4 shift by 4", v, 32'h1234);
    wr(3'd5, 32'h1235);
    rd(3'd0, v); chk("R5 below threshold", 32'(pwm_out[1]), 32'd0);
    wr(3'd5, 32'h1234);
    rd(3'd0, v); chk("R5 equal threshold", 32'(pwm_out[1]), 32'd1);
    wr(3'd1, 32'h7FFF_8000);
    wr(3'd0, 32'hF);
    rd(3'd2, v); chk("R4 shift by 15", v, 32'hFFFF);

    // R6, R8, R12: single control write, period reset
    wr(3'd0, 32'h0); wr(3'd1, 32'h0);
    wr(3'd4, 32'd20); wr(3'd5, 32'd10); wr(3'd6, 32'hFFFF); wr(3'd7, 32'hFFFF);
    wr(3'd0, 32'h1200);
    rd(3'd0, v); chk("R12 one-write config", v & 32'h0FFF_FFFF, 32'h1200);
    count_high(63, h0, h1);
    chk("R6 one-clock pulse per period", 32'(h0), 32'd3);
    chk("R8 half duty", 32'(h1), 32'd33);

    // R7 deglitch period
    wr(3'd0, 32'h0); wr(3'd1, 32'h0);
    wr(3'd0, 32'h1600);
    count_high(66, h0, h1);
    chk("R7 two-clock pulse per period", 32'(h0), 32'd6);
    chk("R7 output 1 high time", 32'(h1), 32'd36);

    // R11 one-shot runs one period and stops
    wr(3'd0, 32'h0); wr(3'd1, 32'h0); wr(3'd4, 32'd5);
    wr(3'd0, 32'h2200);
    repeat (15) @(negedge clk);
    rd(3'd0, v); chk("R11 one-shot cleared", 32'(v[13]), 32'd0);
    rd(3'd1, a); repeat (3) @(negedge clk); rd(3'd1, b);
    chk("R11 stopped at zero", b, 32'd0);
    chk("R11 stays stopped", b, a);

    // R13 wrap
    wr(3'd0, 32'h0); wr(3'd4, 32'hFFFF);
    wr(3'd1, 32'h7FFF_FFFD);
    wr(3'd0, 32'h2000);
    repeat (8) @(negedge clk);
    rd(3'd1, v); chk("R13 wrapped to zero", v, 32'd0);
    rd(3'd0, v); chk("R13 wrap clears one-shot", 32'(v[13]), 32'd0);

    // R10 sticky, R9 non-sticky
    wr(3'd0, 32'h0); wr(3'd1, 32'h0); wr(3'd6, 32'd3);
    wr(3'd0, 32'h1100);
    repeat (8) @(negedge clk);
    rd(3'd0, v); chk("R10 flag set", 32'(v[30]), 32'd1);
    wr(3'd1, 32'h0);
    wr(3'd0, 32'h4000_0100);
    repeat (3) @(negedge clk);
    rd(3'd0, v); chk("R10 held below threshold", 32'(v[30]), 32'd1);
    wr(3'd0, 32'h100);
    repeat (3) @(negedge clk);
    rd(3'd0, v); chk("R10 cleared by write", 32'(v[30]), 32'd0);
    wr(3'd0, 32'h0);
    wr(3'd1, 32'd3);
    repeat (2) @(negedge clk);
    rd(3'd0, v); chk("R9 flag follows output", 32'(v[30]), 32'(pwm_out[2]));
    chk("R9 output at threshold", 32'(pwm_out[2]), 32'd1);

    live = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule